// File: doc/BRIEF.md
# Dual-Sink Hot-Plug Priority Selector

This block sits between one display source and two display sinks, a front port and a rear port, that share an external two-way switch. It watches the hot-plug detect line of each sink and decides which sink the switch should route to. It drives the switch select line and also the single hot-plug line seen by the source. No firmware is involved. Each hot-plug input is synchronized and then timed with a prescaled tick of 0.1 ms (`TICK_DIV` clock cycles). A short low pulse is an interrupt from the sink and leaves the port connected. A low period that reaches `DISC_T` ticks is an unplug. A port only counts as connected after its line has stayed high for `DEB_T` ticks.

When both sinks are connected, the front sink wins. If the selection moves while some sink stays connected, the source has no natural plug edge to react to. The block therefore pulls the source hot-plug line low for `TOGGLE_T` ticks and then releases it. `TOGGLE_T` defaults to 3 ms, which is long enough that the source reads the toggle as a re-plug and not as an interrupt. While the link is up, the selected sink's hot-plug level is passed straight to the source, so interrupt pulses keep their width.

The controller has three states:
- `ST_IDLE`: no sink is connected and the source line is held low.
- `ST_LINK`: the source line follows the selected sink.
- `ST_TOGGLE`: a forced low period is running.

The state transitions are:
- IDLE→LINK when a sink becomes connected. The select line is loaded at the same time.
- LINK→TOGGLE when the preferred port differs from the current selection.
- TOGGLE→LINK when the toggle period ends.
- TOGGLE→TOGGLE, restarting the period, when the preference changes again during a toggle.
- LINK or TOGGLE→IDLE when no sink remains connected.

Top module: `hpd_prio_sel`

## Requirements
- R1: After reset, `sel_rear_o` is 0 (front port selected) and `hpd_src_o` is 0, and both ports are treated as disconnected.
- R2: A port becomes connected only after its synchronized hot-plug line has been high for `DEB_T` consecutive ticks. A shorter high period leaves the port disconnected, and `hpd_src_o` stays 0.
- R3: A low period on a connected port's line that ends before `DISC_T` ticks is an interrupt. This covers both the 0.5–1 ms band and the 1–2 ms band. The port stays connected and the selection does not change.
- R4: A low period that lasts `DISC_T` ticks (2 ms by default) makes the port disconnected.
- R5: While the front port is connected, the next clock has `sel_rear_o` = 0, whatever the state of the rear port.
- R6: While only the rear port is connected, the next clock has `sel_rear_o` = 1.
- R7: When the selection changes in `ST_LINK`, `hpd_src_o` is held 0 for `TOGGLE_T` ticks (3 ms by default) and then follows the newly selected port again.
- R8: In `ST_LINK`, `hpd_src_o` equals the synchronized hot-plug level of the selected port, so an interrupt pulse on that port reaches the source with its own width. A pulse on the unselected port does not reach `hpd_src_o`.
- R9: While no port is connected, `hpd_src_o` is 0 and `sel_rear_o` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hpd_front_i | input | 1 | Hot-plug detect from the front sink (asynchronous) |
| hpd_rear_i | input | 1 | Hot-plug detect from the rear sink (asynchronous) |
| sel_rear_o | output | 1 | Switch select: 0 routes to the front sink, 1 to the rear sink |
| hpd_src_o | output | 1 | Hot-plug line driven toward the video source |

## Verification
The assertions assume the following about the inputs:
- Each hot-plug input holds a level for at least several clocks, so the two-flop synchronizer captures every pulse that matters.
- The tick prescaler runs freely, so the connection state only moves on tick boundaries.

The stimulus keeps within this:
- Inputs change only on the falling clock edge.
- Every pulse width sits several ticks away from the `DEB_T` and `DISC_T` thresholds, so tick phase cannot move a result across a boundary.
- Outputs are sampled at points well inside each expected window.
- The two sinks are never unplugged in the same cycle, which keeps the final selection unambiguous.

// File: rtl/hps_pkg.sv
package hps_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LINK   = 2'd1,
        ST_TOGGLE = 2'd2
    } hps_state_e;

    localparam logic PORT_FRONT = 1'b0;
    localparam logic PORT_REAR  = 1'b1;
    localparam int   NUM_PORTS  = 2;

endpackage

// File: rtl/hps_tick_gen.sv
module hps_tick_gen #(
    parameter int TICK_DIV = 5000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_q == CW'(TICK_DIV - 1)) begin
            div_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/hps_port_mon.sv
module hps_port_mon #(
    parameter int DEB_T  = 20,
    parameter int DISC_T = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic hpd_i,
    output logic lvl_o,
    output logic conn_o
);
    localparam int MAXT = (DEB_T > DISC_T) ? DEB_T : DISC_T;
    localparam int CW   = $clog2(MAXT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    assign lvl_o = sync_q[1];

    // run_q counts ticks during which the line disagrees with conn_o
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            run_q  <= '0;
            conn_o <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], hpd_i};
            if (sync_q[1] == conn_o) begin
                run_q <= '0;
            end else if (tick_i) begin
                if (!conn_o && run_q == CW'(DEB_T - 1)) begin
                    conn_o <= 1'b1;
                    run_q  <= '0;
                end else if (conn_o && run_q == CW'(DISC_T - 1)) begin
                    conn_o <= 1'b0;
                    run_q  <= '0;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/hpd_prio_sel.sv
module hpd_prio_sel
    import hps_pkg::*;
#(
    parameter int TICK_DIV = 5000,
    parameter int DEB_T    = 20,
    parameter int DISC_T   = 20,
    parameter int TOGGLE_T = 30
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hpd_front_i,
    input  logic hpd_rear_i,
    output logic sel_rear_o,
    output logic hpd_src_o
);
    localparam int TW = (TOGGLE_T > 2) ? $clog2(TOGGLE_T) : 1;

    logic                 tick;
    logic [NUM_PORTS-1:0] hpd_raw;
    logic [NUM_PORTS-1:0] lvl;
    logic [NUM_PORTS-1:0] conn;
    logic                 front_conn, rear_conn, any_conn, want;

    hps_state_e state, state_n;
    logic       sel_q, sel_n;
    logic [TW-1:0] tog_cnt, tog_cnt_n;

    assign hpd_raw = {hpd_rear_i, hpd_front_i};

    hps_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        hps_port_mon #(.DEB_T(DEB_T), .DISC_T(DISC_T)) u_mon (
            .clk(clk), .rst_n(rst_n), .tick_i(tick),
            .hpd_i(hpd_raw[p]), .lvl_o(lvl[p]), .conn_o(conn[p])
        );
    end

    assign front_conn = conn[0];
    assign rear_conn  = conn[1];
    assign any_conn   = front_conn | rear_conn;
    assign want       = front_conn ? PORT_FRONT : PORT_REAR;

    // next-state and transition decisions
    always_comb begin
        state_n   = state;
        sel_n     = sel_q;
        tog_cnt_n = tog_cnt;
        unique case (state)
            ST_IDLE: begin
                if (any_conn) begin
                    sel_n   = want;
                    state_n = ST_LINK;
                end
            end
            ST_LINK: begin
                if (!any_conn) begin
                    state_n = ST_IDLE;
                end else if (want != sel_q) begin
                    sel_n     = want;
                    tog_cnt_n = '0;
                    state_n   = ST_TOGGLE;
                end
            end
            ST_TOGGLE: begin
                if (!any_conn) begin
                    state_n = ST_IDLE;
                end else if (want != sel_q) begin
                    sel_n     = want;
                    tog_cnt_n = '0;
                end else if (tick) begin
                    if (tog_cnt == TW'(TOGGLE_T - 1)) state_n = ST_LINK;
                    else tog_cnt_n = tog_cnt + 1'b1;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            sel_q   <= PORT_FRONT;
            tog_cnt <= '0;
        end else begin
            state   <= state_n;
            sel_q   <= sel_n;
            tog_cnt <= tog_cnt_n;
        end
    end

    // outputs
    always_comb begin
        sel_rear_o = sel_q;
        unique case (state)
            ST_LINK:   hpd_src_o = sel_q ? lvl[1] : lvl[0];
            default:   hpd_src_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/hpd_prio_sel_chk.sv
module hpd_prio_sel_chk
    import hps_pkg::*;
#(
    parameter int TOGGLE_T = 30,
    parameter int TW       = 5
) (
    input logic       clk,
    input logic       rst_n,
    input logic       front_conn,
    input logic       rear_conn,
    input hps_state_e state,
    input logic [TW-1:0] tog_cnt,
    input logic       sel_rear_o,
    input logic       hpd_src_o
);
    // R5: front priority
    a_r5_front_wins: assert property (@(posedge clk) disable iff (!rst_n)
        front_conn |=> !sel_rear_o);

    // R6: rear chosen when alone
    a_r6_rear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (rear_conn && !front_conn) |=> sel_rear_o);

    // R7: a selection change out of the link state forces the source line low
    a_r7_toggle_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_LINK && sel_rear_o != $past(sel_rear_o)) |-> !hpd_src_o);

    // R7: toggle timer stays inside its window
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(tog_cnt) < TOGGLE_T);

    // R9: nothing connected means source low
    a_r9_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!front_conn && !rear_conn) |=> !hpd_src_o);

    // R9: nothing connected keeps the selection
    a_r9_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!front_conn && !rear_conn) |=> $stable(sel_rear_o));
endmodule

bind hpd_prio_sel hpd_prio_sel_chk #(.TOGGLE_T(TOGGLE_T), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .front_conn(front_conn), .rear_conn(rear_conn),
    .state(state), .tog_cnt(tog_cnt), .sel_rear_o(sel_rear_o), .hpd_src_o(hpd_src_o)
);

// File: tb/hpd_prio_sel_test.sv
`timescale 1ns/1ps
module hpd_prio_sel_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hpd_front = 1'b0;
    logic hpd_rear  = 1'b0;
    logic sel_rear, hpd_src;
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    // 4 cycles per tick: debounce/disconnect = 80 cycles, toggle = 120 cycles
    hpd_prio_sel #(.TICK_DIV(4), .DEB_T(20), .DISC_T(20), .TOGGLE_T(30)) uut (
        .clk(clk), .rst_n(rst_n), .hpd_front_i(hpd_front), .hpd_rear_i(hpd_rear),
        .sel_rear_o(sel_rear), .hpd_src_o(hpd_src)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        cyc(3);
        chk("R1", "sel after reset", sel_rear, 1'b0);
        chk("R1", "src after reset", hpd_src, 1'b0);
        rst_n = 1'b1;
        cyc(20);
        chk("R1", "src before any plug", hpd_src, 1'b0);
    endtask

    task automatic t_front_plug();
        hpd_front = 1'b1;
        cyc(40);
        chk("R2", "src low during debounce", hpd_src, 1'b0);
        cyc(110);
        chk("R2", "src high after debounce", hpd_src, 1'b1);
        chk("R5", "front selected", sel_rear, 1'b0);
    endtask

    task automatic t_irq_pulses();
        hpd_front = 1'b0;              // 0.8 ms pulse
        cyc(20);
        chk("R8", "pulse reaches source", hpd_src, 1'b0);
        cyc(12);
        hpd_front = 1'b1;
        cyc(20);
        chk("R3", "short pulse keeps link", hpd_src, 1'b1);
        hpd_front = 1'b0;              // 1.5 ms pulse
        cyc(60);
        hpd_front = 1'b1;
        cyc(20);
        chk("R3", "mid pulse keeps link", hpd_src, 1'b1);
        chk("R3", "mid pulse keeps select", sel_rear, 1'b0);
    endtask

    task automatic t_both_plugged();
        hpd_rear = 1'b1;
        cyc(200);
        chk("R5", "front wins with both", sel_rear, 1'b0);
        chk("R5", "src high with both", hpd_src, 1'b1);
    endtask

    task automatic t_front_unplug();
        hpd_front = 1'b0;
        cyc(60);
        chk("R4", "no switch before 2 ms", sel_rear, 1'b0);
        cyc(60);
        chk("R6", "rear selected after unplug", sel_rear, 1'b1);
        chk("R7", "forced low early", hpd_src, 1'b0);
        cyc(60);
        chk("R7", "forced low late", hpd_src, 1'b0);
        cyc(120);
        chk("R7", "released after toggle", hpd_src, 1'b1);
    endtask

    task automatic t_front_return();
        hpd_front = 1'b1;
        cyc(130);
        chk("R5", "front retaken", sel_rear, 1'b0);
        chk("R7", "forced low on retake", hpd_src, 1'b0);
        cyc(200);
        chk("R7", "released on retake", hpd_src, 1'b1);
        hpd_rear = 1'b0;               // pulse on unselected port
        cyc(20);
        chk("R8", "unselected pulse blocked", hpd_src, 1'b1);
        cyc(12);
        hpd_rear = 1'b1;
        cyc(20);
        chk("R8", "select unmoved by other pulse", sel_rear, 1'b0);
    endtask

    task automatic t_idle();
        hpd_rear = 1'b0;
        cyc(200);
        chk("R4", "rear unplug leaves front", hpd_src, 1'b1);
        hpd_front = 1'b0;
        cyc(200);
        chk("R9", "src low none connected", hpd_src, 1'b0);
        chk("R9", "sel held front", sel_rear, 1'b0);
        hpd_rear = 1'b1;
        cyc(200);
        chk("R6", "rear alone selected", sel_rear, 1'b1);
        chk("R6", "rear alone src high", hpd_src, 1'b1);
        hpd_rear = 1'b0;
        cyc(200);
        chk("R9", "src low after rear gone", hpd_src, 1'b0);
        chk("R9", "sel held rear", sel_rear, 1'b1);
        hpd_front = 1'b1;              // 1 ms blip, below debounce
        cyc(40);
        hpd_front = 1'b0;
        cyc(200);
        chk("R2", "blip not a plug src", hpd_src, 1'b0);
        chk("R2", "blip not a plug sel", sel_rear, 1'b1);
    endtask

    initial begin
        t_reset();
        t_front_plug();
        t_irq_pulses();
        t_both_plugged();
        t_front_unplug();
        t_front_return();
        t_idle();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule